// File: doc/BRIEF.md
# Constant Off-Time Current Chopper Sequencer

This block sequences one sinking bridge leg through a fixed four-phase chopping loop that regulates motor current with a constant off interval. While conducting, the low-side switch of the leg is on. A synchronous trip input reports that the sensed current has risen above its reference. Once that trip is accepted, the low-side switch opens and a dead interval follows. The high-side switch of the same leg then closes, so the winding current recirculates in the upper half of the bridge and decays slowly. When the off count runs out, the high-side switch opens. A second dead interval passes before the low-side switch closes again.

Every interval is a count of clock cycles taken from an input bus. Each count is captured when its phase begins. A blanking window at the start of each conduction phase masks the recovery spike on the trip input. A minimum on length keeps conduction going even when an accepted trip arrives early. When enable is low the block parks in a ready state with both switches open. It restarts with a fresh conduction phase, blanking included, once enable returns high.

Top module: `chop_ctrl`

## Requirements
- R1: `phase` is encoded as 0 = conduct, 1 = first dead interval, 2 = slow-decay recirculation, 3 = second dead interval. While enabled it only ever advances 0→1→2→3→0.
- R2: A trip sampled high at conduction cycle k (counting from 0 at the first cycle with `ls_on` high) ends conduction if k ≥ the blanking count. Conduction then lasts max(k+1, minimum-on count, 1) cycles and `ls_on` falls after the last of them.
- R3: A trip sampled during the first blanking-count cycles of conduction has no effect: `ls_on` stays high.
- R4: Conduction lasts at least max(minimum-on count, 1) cycles. An accepted trip that arrives earlier, even as a single-cycle pulse, is held and ends conduction when that minimum is reached.
- R5: The first dead interval lasts max(dead count, 1) cycles with both flags low. `hs_on` is then high for max(off count, 1) cycles. The time from `ls_on` falling to `hs_on` falling is therefore the off count plus one dead interval.
- R6: After `hs_on` falls, both flags stay low for max(dead count, 1) cycles, and then `ls_on` rises.
- R7: `ls_on` and `hs_on` are never high in the same cycle. Neither flag rises in the cycle directly after the other one was high.
- R8: An edge that samples `en` low leaves both flags low and `phase` at 0. The first edge that samples `en` high again starts conduction, with blanking counted from that point.
- R9: Each count is taken from its input at the edge that enters its phase. A change to a count input during a phase does not alter that phase's length.
- R10: Right after reset both flags are low and `phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low parks the leg with both switches open |
| trip | input | 1 | Synchronous comparator trip, sense above reference |
| blank_cyc | input | CNT_W | Blanking window in cycles at the start of conduction |
| minon_cyc | input | CNT_W | Minimum conduction length in cycles |
| dead_cyc | input | CNT_W | Dead interval length in cycles |
| off_cyc | input | CNT_W | Slow-decay recirculation length in cycles |
| phase | output | 2 | Current phase, encoded as in R1 |
| ls_on | output | 1 | Low-side enable of the sinking leg |
| hs_on | output | 1 | High-side synchronous-rectification enable of the same leg |

## Verification
A set of vectors varies the blanking, minimum-on, dead and off counts together with the trip arrival point. Each vector measures the length of all four phases. These vectors separate a trip that is accepted at once, one held back by blanking and one held back by the minimum on length, and they include zero counts that must still give one-cycle phases. Directed cases check three further things: a lone trip pulse that falls inside blanking and is ignored, a lone early pulse that must be remembered until the minimum on length is reached, and count inputs changed in the middle of a phase. A last case drops enable partway through recirculation, to show that the block parks at once and restarts with fresh blanking.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_ON  = 2'd0,
    PH_DT1 = 2'd1,
    PH_SR  = 2'd2,
    PH_DT2 = 2'd3
  } chop_phase_e;

  // A span of lim cycles is over in the cycle whose index is lim-1 (zero counts as one).
  function automatic logic span_over(input int unsigned idx, input int unsigned lim);
    return (idx + 1) >= lim;
  endfunction

  // The blanking window covers indices 0 .. blank-1.
  function automatic logic blank_over(input int unsigned idx, input int unsigned blank);
    return idx >= blank;
  endfunction

  function automatic chop_phase_e phase_after(input chop_phase_e p);
    chop_phase_e n;
    case (p)
      PH_ON:   n = PH_DT1;
      PH_DT1:  n = PH_SR;
      PH_SR:   n = PH_DT2;
      default: n = PH_ON;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/chop_span_timer.sv
module chop_span_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] lim_in,
  output logic [W-1:0] idx,
  output logic         done
);
  import chop_pkg::*;

  localparam logic [W-1:0] IDX_MAX = '1;

  logic [W-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      lim_q <= '0;
    end else if (start) begin
      idx   <= '0;
      lim_q <= lim_in;
    end else if (idx != IDX_MAX) begin
      idx <= idx + 1'b1;
    end
  end

  assign done = span_over(32'(idx), 32'(lim_q));

endmodule

// File: rtl/chop_on_gate.sv
module chop_on_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         in_on,
  input  logic [W-1:0] blank_in,
  input  logic [W-1:0] idx,
  input  logic         min_met,
  input  logic         trip,
  output logic         trip_ok,
  output logic         go_off
);
  import chop_pkg::*;

  logic [W-1:0] blank_q;
  logic         held_q;

  assign trip_ok = in_on && trip && blank_over(32'(idx), 32'(blank_q));
  assign go_off  = in_on && min_met && (trip_ok || held_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
      held_q  <= 1'b0;
    end else if (start) begin
      blank_q <= blank_in;
      held_q  <= 1'b0;
    end else if (trip_ok && !min_met) begin
      held_q <= 1'b1;
    end
  end

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trip,
  input  logic [CNT_W-1:0] blank_cyc,
  input  logic [CNT_W-1:0] minon_cyc,
  input  logic [CNT_W-1:0] dead_cyc,
  input  logic [CNT_W-1:0] off_cyc,
  output logic [1:0]       phase,
  output logic             ls_on,
  output logic             hs_on
);
  import chop_pkg::*;

  localparam int PH_W = $bits(chop_phase_e);

  chop_phase_e      ph_q;
  logic             run_q;
  logic             in_on;
  logic             span_done;
  logic             go_off;
  logic             trip_ok;
  logic             advance;
  logic             start;
  chop_phase_e      ph_next;
  logic [CNT_W-1:0] lim_sel;
  logic [CNT_W-1:0] idx;

  assign in_on   = run_q && (ph_q == PH_ON);
  assign advance = run_q && ((ph_q == PH_ON) ? go_off : span_done);
  assign start   = en && (!run_q || advance);
  assign ph_next = run_q ? phase_after(ph_q) : PH_ON;

  always_comb begin
    case (ph_next)
      PH_ON:   lim_sel = minon_cyc;
      PH_SR:   lim_sel = off_cyc;
      default: lim_sel = dead_cyc;
    endcase
  end

  chop_span_timer #(.W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .lim_in (lim_sel),
    .idx    (idx),
    .done   (span_done)
  );

  chop_on_gate #(.W(CNT_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_on    (in_on),
    .blank_in (blank_cyc),
    .idx      (idx),
    .min_met  (span_done),
    .trip     (trip),
    .trip_ok  (trip_ok),
    .go_off   (go_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= PH_ON;
    end else if (!en) begin
      run_q <= 1'b0;
      ph_q  <= PH_ON;
    end else if (start) begin
      run_q <= 1'b1;
      ph_q  <= ph_next;
    end
  end

  assign phase = PH_W'(ph_q);
  assign ls_on = run_q && (ph_q == PH_ON);
  assign hs_on = run_q && (ph_q == PH_SR);

endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [W-1:0] minon_cyc,
  input logic [1:0]   phase,
  input logic         ls_on,
  input logic         hs_on
);
  logic [W-1:0] mon_prev;
  logic [W-1:0] mon_lim;
  logic [31:0]  on_len;
  logic         ls_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_prev <= '0;
      mon_lim  <= '0;
      on_len   <= '0;
      ls_prev  <= 1'b0;
    end else begin
      mon_prev <= minon_cyc;
      ls_prev  <= ls_on;
      if (ls_on && !ls_prev) begin
        on_len  <= 32'd1;
        mon_lim <= mon_prev;
      end else if (ls_on) begin
        on_len <= on_len + 32'd1;
      end
    end
  end

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_on && hs_on));

  p_hs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> !$past(ls_on));

  p_ls_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> !$past(hs_on));

  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && phase != $past(phase)) |-> phase == $past(phase) + 2'd1);

  p_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ls_on && !hs_on && phase == 2'd0));

  // R4: a conduction interval that ends while enabled meets its minimum length
  p_min_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_on && ls_prev && $past(en)) |->
      (on_len >= ((mon_lim == '0) ? 32'd1 : 32'(mon_lim))));

endmodule

bind chop_ctrl chop_ctrl_chk #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .minon_cyc (minon_cyc),
  .phase     (phase),
  .ls_on     (ls_on),
  .hs_on     (hs_on)
);

// File: tb/sim_chop_ctrl.sv
module sim_chop_ctrl;
  localparam int W  = 16;
  localparam int NV = 6;
  // blank, minon, dead, off, trip_from, exp_on, exp_dead, exp_sr
  localparam int TBL [0:NV-1][0:7] = '{
    '{2, 3, 2,  5, 0,  3, 2,  5},
    '{1, 6, 1,  3, 1,  6, 1,  3},
    '{4, 2, 3,  4, 0,  5, 3,  4},
    '{0, 1, 0,  0, 7,  8, 1,  1},
    '{3, 3, 4, 10, 9, 10, 4, 10},
    '{8, 2, 2,  2, 3,  9, 2,  2}
  };
  localparam int NONE = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic trip = 1'b0;
  logic [W-1:0] blank_cyc = '0, minon_cyc = '0, dead_cyc = '0, off_cyc = '0;
  logic [1:0] phase;
  logic ls_on, hs_on;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  chop_ctrl #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .trip(trip),
    .blank_cyc(blank_cyc), .minon_cyc(minon_cyc), .dead_cyc(dead_cyc), .off_cyc(off_cyc),
    .phase(phase), .ls_on(ls_on), .hs_on(hs_on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_counts(input int b, input int m, input int d, input int o);
    blank_cyc = W'(b); minon_cyc = W'(m); dead_cyc = W'(d); off_cyc = W'(o);
  endtask

  // park for two cycles, load counts, re-enable; returns at first conduction negedge
  task automatic restart(input int b, input int m, input int d, input int o);
    en = 1'b0; trip = 1'b0;
    @(negedge clk); @(negedge clk);
    set_counts(b, m, d, o);
    en = 1'b1;
    @(negedge clk);
  endtask

  // count conduction cycles; trip held from index hold, or a single pulse at index pulse
  task automatic cnt_on(input int hold, input int pulse, output int n, output bit ph_ok);
    n = 0; ph_ok = 1'b1;
    while (ls_on && n < 1000) begin
      if (phase != 2'd0 || hs_on) ph_ok = 1'b0;
      trip = (n >= hold) || (n == pulse);
      n++;
      @(negedge clk);
    end
    trip = 1'b0;
  endtask

  task automatic cnt_gap(input logic [1:0] ph, output int n, output bit ph_ok);
    n = 0; ph_ok = 1'b1;
    while (!ls_on && !hs_on && n < 1000) begin
      if (phase != ph) ph_ok = 1'b0;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cnt_sr(input int chg_at, input int new_off, input int new_dead,
                        output int n, output bit ph_ok);
    n = 0; ph_ok = 1'b1;
    while (hs_on && n < 1000) begin
      if (phase != 2'd2 || ls_on) ph_ok = 1'b0;
      if (n == chg_at) begin off_cyc = W'(new_off); dead_cyc = W'(new_dead); end
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    bit ok;
    set_counts(2, 3, 2, 5);
    repeat (3) @(negedge clk);
    chk(!ls_on && !hs_on && phase == 2'd0, "R10 reset state", int'({phase, ls_on, hs_on}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ls_on && !hs_on, "R10 idle after reset", int'({ls_on, hs_on}), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      restart(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3]);
      chk(ls_on === 1'b1, "R8 conduct one edge after enable", int'(ls_on), 1);
      cnt_on(TBL[v][4], NONE, n, ok);
      chk(n == TBL[v][5], "R2 conduction length", n, TBL[v][5]);
      chk(ok, "R1 phase 0 in conduction", int'(ok), 1);
      cnt_gap(2'd1, n, ok);
      chk(n == TBL[v][6] && ok, "R5 first dead interval", n, TBL[v][6]);
      cnt_sr(NONE, 0, 0, n, ok);
      chk(n == TBL[v][7] && ok, "R5 recirculation length", n, TBL[v][7]);
      cnt_gap(2'd3, n, ok);
      chk(n == TBL[v][6] && ok, "R6 second dead interval", n, TBL[v][6]);
      chk(ls_on === 1'b1, "R6 conduction resumes", int'(ls_on), 1);
    end

    // steady state second period with last vector counts: blanking applies again
    cnt_on(0, NONE, n, ok);
    chk(n == 9, "R3 blanking each period", n, 9);
    cnt_gap(2'd1, n, ok); cnt_sr(NONE, 0, 0, n, ok); cnt_gap(2'd3, n, ok);

    // R3: a lone pulse inside blanking is ignored, a later one ends conduction
    restart(4, 1, 1, 1);
    cnt_on(NONE, 1, n, ok);
    // pulse at index 1 only: conduction must persist; cnt_on stops at 1000 cap
    chk(n == 1000, "R3 pulse during blanking ignored", n, 1000);
    restart(4, 1, 1, 1);
    begin
      int k;
      k = 0;
      while (k < 11) begin
        trip = (k == 1) || (k == 10);
        k++;
        @(negedge clk);
      end
      trip = 1'b0;
      chk(!ls_on && !hs_on && phase == 2'd1, "R3 trip after blanking ends conduction",
          int'(phase), 1);
    end

    // R4: single early accepted pulse held until minimum on length
    restart(0, 6, 1, 1);
    cnt_on(NONE, 1, n, ok);
    chk(n == 6, "R4 held trip ends at minimum", n, 6);

    // R9: counts changed inside recirculation
    restart(0, 1, 2, 6);
    cnt_on(0, NONE, n, ok);
    cnt_gap(2'd1, n, ok);
    cnt_sr(1, 2, 3, n, ok);
    chk(n == 6, "R9 recirculation uses entry count", n, 6);
    cnt_gap(2'd3, n, ok);
    chk(n == 3, "R9 second dead uses count at its entry", n, 3);
    cnt_on(0, NONE, n, ok);
    cnt_gap(2'd1, n, ok);
    cnt_sr(NONE, 0, 0, n, ok);
    chk(n == 2, "R9 next period uses new off count", n, 2);

    // R8: enable dropped during recirculation, restart with fresh blanking
    restart(0, 1, 1, 20);
    cnt_on(0, NONE, n, ok);
    cnt_gap(2'd1, n, ok);
    @(negedge clk); @(negedge clk);
    chk(hs_on === 1'b1, "R5 in recirculation before park", int'(hs_on), 1);
    en = 1'b0;
    @(negedge clk);
    chk(!ls_on && !hs_on && phase == 2'd0, "R8 park on enable low",
        int'({phase, ls_on, hs_on}), 0);
    blank_cyc = W'(4);
    trip = 1'b1;
    @(negedge clk);
    chk(!ls_on && !hs_on, "R8 stays parked", int'({ls_on, hs_on}), 0);
    en = 1'b1;
    @(negedge clk);
    chk(ls_on === 1'b1, "R8 restart conducts", int'(ls_on), 1);
    cnt_on(0, NONE, n, ok);
    chk(n == 5, "R8 fresh blanking after restart", n, 5);
    chk(!(ls_on && hs_on), "R7 flags exclusive", int'({ls_on, hs_on}), 0);

    finish_run();
  end

endmodule